// File: doc/BRIEF.md
# Interrupt Event Latch and Read-to-Clear Status Unit

This unit sits between the datapath of a serial bus controller and the software register window. It keeps twelve raw status positions. Eight of them are sticky event bits, set by one-cycle pulses from the bus engine and the FIFO logic. Two are level flags that hardware recomputes every cycle from the transmit and receive FIFO fill levels against programmable thresholds. The remaining two positions always read zero. A mask register selects which raw bits reach the masked status. The single interrupt output is the OR of the masked status.

Software clears sticky bits by reading. Each sticky bit has its own clear address, and one global clear address covers them all. A read returns the value the bit had before the clear. When the bus engine reports a transmit abort, the unit latches the abort cause. For as long as the abort bit stays set, it drives a hold signal that keeps the transmit FIFO flushed. Reading the abort clear address or the global clear address releases the flush and wipes the cause.

Top module: `irq_status_unit`

## Requirements
- R1: Raw status (word address 2) holds, at these bit positions: 0 RX underflow, 1 RX overflow, 2 RX threshold flag, 3 TX overflow, 4 TX threshold flag, 6 TX abort, 8 activity, 9 stop seen, 10 start seen, 11 general call; bits 5 and 7 read 0. The compact event input `evt_i` maps index 0..7 to raw bits 0,1,3,6,8,9,10,11. After reset every sticky bit is 0.
- R2: The mask register (word address 1, bits 11:0, writable) resets to 0x8FF. Masked status (word address 0) reads raw AND mask.
- R3: `irq_o` is high exactly when the masked status is nonzero.
- R4: A sticky bit is set by its event pulse and then holds. A read of word address 16+n, where n is the raw position of the bit, clears it and returns the value before the clear in bit 0. If an event and a clear read of the same bit fall in one cycle, the bit ends up set.
- R5: A read of word address 5 clears every sticky bit and the abort-cause register, and returns in bit 0 the OR of the sticky bits before the clear.
- R6: An abort event ORs `abort_src_i` into the abort-cause register (word address 6). `tx_flush_o` is high while the abort bit is set. Reading address 22 releases the flush and zeroes the cause register. A same-cycle abort event wins.
- R7: While `bus_busy_i` is high, neither address 24 nor address 5 clears the activity bit.
- R8: The RX threshold (word address 3) and TX threshold (word address 4) registers are 8 bits wide and reset to 0. Any value above DEPTH acts as DEPTH. The RX flag is set when the RX level is nonzero and at least the effective threshold. The TX flag is set when the TX level is at most the effective threshold.
- R9: The threshold flags are not affected by any clear read, including reads of addresses 18, 20 and 5.
- R10: Read data appears on `rdata_o` one cycle after `rd_en_i` and then holds. Unmapped addresses, and clear addresses of non-sticky positions, read 0. Writes to any address other than 1, 3 and 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | One-cycle event pulses, compact order per R1 |
| abort_src_i | input | CAUSE_W | Abort cause bits, taken with the abort event |
| bus_busy_i | input | 1 | Bus engine still active |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | max(THR_W,12) | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Combined interrupt |
| tx_flush_o | output | 1 | Holds transmit FIFO flushed |

## Verification
The bench aims at an event and a clear read of the same bit in one cycle. A design that lets the clear win would lose that event, and the following raw read would show 0. It reads the activity clear address and the global clear address while the bus is busy. A design that clears anyway reports 0 where 0x100 is expected. It drives both FIFO levels across each threshold, including thresholds programmed above the depth, and issues clear reads while the flags are up. This exposes off-by-one compares, missing saturation and flags that software can wrongly clear. It also checks that the abort flush and cause survive an unrelated clear and drop on the abort clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int NBITS = 12;
   localparam int NEV   = 8;

   localparam int B_RXU = 0;
   localparam int B_RXO = 1;
   localparam int B_RXT = 2;
   localparam int B_TXO = 3;
   localparam int B_TXT = 4;
   localparam int B_TXA = 6;
   localparam int B_ACT = 8;
   localparam int B_STP = 9;
   localparam int B_STA = 10;
   localparam int B_GC  = 11;

   localparam int E_TXA = 3;

   localparam logic [NBITS-1:0] STICKY = 12'hF4B;

   localparam int A_MSTAT   = 0;
   localparam int A_MASK    = 1;
   localparam int A_RAW     = 2;
   localparam int A_RXTHR   = 3;
   localparam int A_TXTHR   = 4;
   localparam int A_GCLR    = 5;
   localparam int A_CAUSE   = 6;
   localparam int A_CLRBASE = 16;

   function automatic int ev_pos(input int k);
      case (k)
         0:       return B_RXU;
         1:       return B_RXO;
         2:       return B_TXO;
         3:       return B_TXA;
         4:       return B_ACT;
         5:       return B_STP;
         6:       return B_STA;
         default: return B_GC;
      endcase
   endfunction
endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   // R4: an event always leaves the bit set, even against a clear
   a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   // R4: with no event and no clear the bit keeps its value
   a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q_o));
   // R4: a clear without an event drops the bit
   a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/irq_thresh_flag.sv
module irq_thresh_flag #(
   parameter int DEPTH = 16,
   parameter int THR_W = 8,
   parameter int LVL_W = 5,
   parameter bit IS_RX = 1'b1
) (
   input  logic [THR_W-1:0] thr_i,
   input  logic [LVL_W-1:0] level_i,
   output logic             flag_o
);
   localparam int CW = ((THR_W > LVL_W) ? THR_W : LVL_W) + 1;

   if (DEPTH >= (1 << LVL_W)) begin : g_bad_lvl
      $error("irq_thresh_flag: LVL_W too small for DEPTH");
   end

   logic [CW-1:0] thr_x, lvl_x, eff_x;
   assign thr_x = CW'(thr_i);
   assign lvl_x = CW'(level_i);
   assign eff_x = (thr_x >= CW'(DEPTH)) ? CW'(DEPTH) : thr_x;

   if (IS_RX) begin : g_rx
      assign flag_o = (lvl_x != '0) && (lvl_x >= eff_x);
      always_comb begin
         if (level_i == '0)
            a_r8_rx_empty_quiet: assert (!flag_o);
      end
   end else begin : g_tx
      assign flag_o = (lvl_x <= eff_x);
      always_comb begin
         if (level_i == '0)
            a_r8_tx_empty_flags: assert (flag_o);
      end
   end
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port
   import irq_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int DATA_W  = 32,
   parameter int THR_W   = 8,
   parameter int CAUSE_W = 17
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [NBITS-1:0]   raw_i,
   input  logic [NBITS-1:0]   mask_i,
   input  logic [THR_W-1:0]   rxthr_i,
   input  logic [THR_W-1:0]   txthr_i,
   input  logic [CAUSE_W-1:0] cause_i,
   output logic [DATA_W-1:0]  rdata_o
);
   logic [DATA_W-1:0] val;

   always_comb begin
      val = '0;
      if (addr_i == ADDR_W'(A_MSTAT)) val = DATA_W'(raw_i & mask_i);
      if (addr_i == ADDR_W'(A_MASK))  val = DATA_W'(mask_i);
      if (addr_i == ADDR_W'(A_RAW))   val = DATA_W'(raw_i);
      if (addr_i == ADDR_W'(A_RXTHR)) val = DATA_W'(rxthr_i);
      if (addr_i == ADDR_W'(A_TXTHR)) val = DATA_W'(txthr_i);
      if (addr_i == ADDR_W'(A_CAUSE)) val = DATA_W'(cause_i);
      if (addr_i == ADDR_W'(A_GCLR))  val = DATA_W'(|(raw_i & STICKY));
      for (int b = 0; b < NBITS; b++) begin
         if (STICKY[b] && (addr_i == ADDR_W'(A_CLRBASE + b)))
            val = DATA_W'(raw_i[b]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rdata_o <= '0;
      else if (rd_en_i) rdata_o <= val;
   end

   // R10: read data holds between reads
   a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
   import irq_pkg::*;
#(
   parameter int               DEPTH    = 16,
   parameter int               THR_W    = 8,
   parameter int               ADDR_W   = 6,
   parameter int               DATA_W   = 32,
   parameter int               CAUSE_W  = 17,
   parameter logic [NBITS-1:0] MASK_RST = 12'h8FF,
   parameter int               LVL_W    = $clog2(DEPTH + 1),
   parameter int               WR_W     = (THR_W > NBITS) ? THR_W : NBITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NEV-1:0]     evt_i,
   input  logic [CAUSE_W-1:0] abort_src_i,
   input  logic               bus_busy_i,
   input  logic [LVL_W-1:0]   tx_level_i,
   input  logic [LVL_W-1:0]   rx_level_i,
   input  logic               wr_en_i,
   input  logic               rd_en_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [WR_W-1:0]    wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               irq_o,
   output logic               tx_flush_o
);
   if ((A_CLRBASE + NBITS) > (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_status_unit: ADDR_W too small for clear window");
   end
   if (DATA_W < NBITS || DATA_W < CAUSE_W || DATA_W < THR_W) begin : g_bad_data
      $error("irq_status_unit: DATA_W too small");
   end
   if (THR_W < LVL_W) begin : g_bad_thr
      $error("irq_status_unit: THR_W cannot span the FIFO depth");
   end

   logic [NBITS-1:0]   mask_q;
   logic [THR_W-1:0]   rxthr_q, txthr_q;
   logic [CAUSE_W-1:0] cause_q;
   logic [NBITS-1:0]   raw_w;
   logic               gclr_rd, aclr_rd;

   assign gclr_rd = rd_en_i && (addr_i == ADDR_W'(A_GCLR));
   assign aclr_rd = rd_en_i && (addr_i == ADDR_W'(A_CLRBASE + B_TXA));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= MASK_RST;
         rxthr_q <= '0;
         txthr_q <= '0;
      end else if (wr_en_i) begin
         if (addr_i == ADDR_W'(A_MASK))  mask_q  <= wdata_i[NBITS-1:0];
         if (addr_i == ADDR_W'(A_RXTHR)) rxthr_q <= wdata_i[THR_W-1:0];
         if (addr_i == ADDR_W'(A_TXTHR)) txthr_q <= wdata_i[THR_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= ((gclr_rd || aclr_rd) ? '0 : cause_q)
                             | (evt_i[E_TXA] ? abort_src_i : '0);
   end

   for (genvar k = 0; k < NEV; k++) begin : g_evt
      localparam int POS = ev_pos(k);
      logic clr_k;
      assign clr_k = rd_en_i
                     && ((addr_i == ADDR_W'(A_CLRBASE + POS)) || (addr_i == ADDR_W'(A_GCLR)))
                     && ((POS != B_ACT) || !bus_busy_i);
      irq_sticky_bit u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (evt_i[k]),
         .clr_i (clr_k),
         .q_o   (raw_w[POS])
      );
   end

   irq_thresh_flag #(.DEPTH(DEPTH), .THR_W(THR_W), .LVL_W(LVL_W), .IS_RX(1'b1)) u_rx_thr (
      .thr_i   (rxthr_q),
      .level_i (rx_level_i),
      .flag_o  (raw_w[B_RXT])
   );

   irq_thresh_flag #(.DEPTH(DEPTH), .THR_W(THR_W), .LVL_W(LVL_W), .IS_RX(1'b0)) u_tx_thr (
      .thr_i   (txthr_q),
      .level_i (tx_level_i),
      .flag_o  (raw_w[B_TXT])
   );

   assign raw_w[5] = 1'b0;
   assign raw_w[7] = 1'b0;

   assign irq_o      = |(raw_w & mask_q);
   assign tx_flush_o = raw_w[B_TXA];

   irq_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .THR_W(THR_W), .CAUSE_W(CAUSE_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en_i (rd_en_i),
      .addr_i  (addr_i),
      .raw_i   (raw_w),
      .mask_i  (mask_q),
      .rxthr_i (rxthr_q),
      .txthr_i (txthr_q),
      .cause_i (cause_q),
      .rdata_o (rdata_o)
   );

   // R6: the flush stays on until an abort or global clear read
   a_r6_flush_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_flush_o && !aclr_rd && !gclr_rd) |=> tx_flush_o);
   // R6: the abort clear read releases the flush and the cause
   a_r6_flush_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (aclr_rd && !evt_i[E_TXA]) |=> (!tx_flush_o && cause_q == '0));
   // R5: the global clear read empties the cause register
   a_r5_cause_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (gclr_rd && !evt_i[E_TXA]) |=> (cause_q == '0));
   // R7: a busy bus protects the activity bit
   a_r7_busy_keeps_activity: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_w[B_ACT] && bus_busy_i) |=> raw_w[B_ACT]);
   // R3: an all-zero mask silences the interrupt
   a_r3_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o);
endmodule

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
   localparam int LVL_W = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt_i = '0;
   logic [16:0] abort_src_i = '0;
   logic        bus_busy_i = 1'b0;
   logic [LVL_W-1:0] tx_level_i = 5'd5;
   logic [LVL_W-1:0] rx_level_i = '0;
   logic        wr_en_i = 1'b0;
   logic        rd_en_i = 1'b0;
   logic [5:0]  addr_i = '0;
   logic [11:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        irq_o, tx_flush_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        cap = 1'b0;

   always #10 clk = ~clk;

   irq_status_unit u_irq_status_unit (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .abort_src_i(abort_src_i),
      .bus_busy_i(bus_busy_i), .tx_level_i(tx_level_i), .rx_level_i(rx_level_i),
      .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .irq_o(irq_o), .tx_flush_o(tx_flush_o)
   );

   always @(posedge clk) cap <= rd_en_i;

   always @(negedge clk) begin
      if (cap && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_chk++;
         if (rdata_o !== e) begin
            n_bad++;
            $display("FAIL %s: rdata actual 0x%0h expected 0x%0h", t, rdata_o, e);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic rd(input int a, input logic [31:0] e, input string t);
      rd_en_i = 1'b1;
      addr_i  = 6'(a);
      exp_q.push_back(e);
      tag_q.push_back(t);
      step();
      rd_en_i = 1'b0;
   endtask

   task automatic wr(input int a, input logic [11:0] d);
      wr_en_i = 1'b1;
      addr_i  = 6'(a);
      wdata_i = d;
      step();
      wr_en_i = 1'b0;
   endtask

   task automatic ev(input int k);
      evt_i = 8'(1 << k);
      step();
      evt_i = '0;
   endtask

   task automatic chk(input logic act, input logic e, input string t);
      n_chk++;
      if (act !== e) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b", t, act, e);
      end
   endtask

   function automatic int pos_of(input int k);
      case (k)
         0: return 0;  1: return 1;  2: return 3;  3: return 6;
         4: return 8;  5: return 9;  6: return 10; default: return 11;
      endcase
   endfunction

   task automatic finish_run();
      step(); step();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();

      // reset state
      rd(1, 32'h8FF, "R2 mask reset");
      rd(2, 32'h0,   "R1 raw reset");
      rd(0, 32'h0,   "R2 masked reset");
      chk(irq_o, 1'b0, "R3 irq reset");
      chk(tx_flush_o, 1'b0, "R6 flush reset");

      // each sticky event at its position, clear by its own address
      for (int k = 0; k < 8; k++) begin
         ev(k);
         rd(2, 32'(1 << pos_of(k)), "R1 raw position");
         rd(16 + pos_of(k), 32'h1, "R4 clear returns old");
         rd(2, 32'h0, "R4 raw after clear");
         rd(16 + pos_of(k), 32'h0, "R4 clear of zero bit");
      end

      // default mask hides activity and stop, shows overflow
      ev(4);
      ev(5);
      rd(0, 32'h0, "R2 default mask hides 8,9");
      chk(irq_o, 1'b0, "R3 irq masked off");
      ev(1);
      rd(0, 32'h002, "R2 masked overflow");
      chk(irq_o, 1'b1, "R3 irq on");
      rd(5, 32'h1, "R5 global returns or");
      rd(2, 32'h0, "R5 raw after global");
      chk(irq_o, 1'b0, "R3 irq after global");

      // custom mask
      wr(1, 12'h200);
      ev(5);
      rd(0, 32'h200, "R2 custom mask");
      chk(irq_o, 1'b1, "R3 irq via stop");
      ev(0);
      rd(0, 32'h200, "R2 underflow masked");
      rd(2, 32'h201, "R1 raw both");
      rd(25, 32'h1, "R4 clear stop");
      chk(irq_o, 1'b0, "R3 irq drops");
      rd(5, 32'h1, "R5 global");
      wr(1, 12'h8FF);

      // same-cycle event and clear read
      evt_i = 8'h20;
      rd(25, 32'h0, "R4 collide on clear bit");
      evt_i = '0;
      rd(2, 32'h200, "R4 event wins");
      evt_i = 8'h20;
      rd(25, 32'h1, "R4 collide on set bit");
      evt_i = '0;
      rd(2, 32'h200, "R4 event wins again");
      rd(25, 32'h1, "R4 plain clear");
      rd(2, 32'h0, "R4 cleared");

      // abort flush and cause
      abort_src_i = 17'h01001;
      ev(3);
      chk(tx_flush_o, 1'b1, "R6 flush on abort");
      rd(6, 32'h1001, "R6 cause latched");
      abort_src_i = 17'h00008;
      ev(3);
      rd(6, 32'h1009, "R6 cause accumulates");
      rd(17, 32'h0, "R6 unrelated clear");
      chk(tx_flush_o, 1'b1, "R6 flush holds");
      rd(22, 32'h1, "R6 abort clear");
      chk(tx_flush_o, 1'b0, "R6 flush released");
      rd(6, 32'h0, "R6 cause cleared");

      // global clear of several bits and the cause
      abort_src_i = 17'h10000;
      ev(3);
      ev(7);
      ev(2);
      rd(2, 32'h848, "R1 raw abort gc txo");
      rd(6, 32'h10000, "R6 cause");
      rd(5, 32'h1, "R5 global");
      rd(2, 32'h0, "R5 raw empty");
      rd(6, 32'h0, "R5 cause empty");
      chk(tx_flush_o, 1'b0, "R5 flush released");
      rd(5, 32'h0, "R5 global on empty");
      abort_src_i = '0;

      // activity while bus busy
      ev(4);
      bus_busy_i = 1'b1;
      rd(24, 32'h1, "R7 busy clear returns");
      rd(2, 32'h100, "R7 busy keeps bit");
      rd(5, 32'h1, "R7 busy global");
      rd(2, 32'h100, "R7 busy keeps after global");
      bus_busy_i = 1'b0;
      rd(24, 32'h1, "R7 idle clear");
      rd(2, 32'h0, "R7 cleared when idle");

      // RX threshold
      wr(3, 12'd4);
      rx_level_i = 5'd3;
      rd(2, 32'h0, "R8 rx below");
      rx_level_i = 5'd4;
      rd(2, 32'h004, "R8 rx at threshold");
      rx_level_i = 5'd9;
      rd(2, 32'h004, "R8 rx above");
      rd(5, 32'h0, "R9 global with flag");
      rd(2, 32'h004, "R9 rx flag survives global");
      rd(18, 32'h0, "R9 rx clear address");
      rd(2, 32'h004, "R9 rx flag survives");
      wr(3, 12'd200);
      rd(3, 32'd200, "R8 rx thr readback");
      rx_level_i = 5'd15;
      rd(2, 32'h0, "R8 saturated below");
      rx_level_i = 5'd16;
      rd(2, 32'h004, "R8 saturated full");
      wr(3, 12'd0);
      rx_level_i = 5'd0;
      rd(2, 32'h0, "R8 rx empty zero thr");

      // TX threshold
      wr(4, 12'd3);
      tx_level_i = 5'd3;
      rd(2, 32'h010, "R8 tx at threshold");
      tx_level_i = 5'd4;
      rd(2, 32'h0, "R8 tx above");
      wr(4, 12'hFF);
      tx_level_i = 5'd16;
      rd(2, 32'h010, "R8 tx saturated");
      chk(irq_o, 1'b1, "R3 irq from tx flag");
      rd(20, 32'h0, "R9 tx clear address");
      rd(2, 32'h010, "R9 tx flag survives");
      wr(4, 12'd0);
      tx_level_i = 5'd5;
      rd(4, 32'h0, "R8 tx thr readback");
      chk(irq_o, 1'b0, "R3 irq off");

      // unmapped addresses and ignored writes
      rd(63, 32'h0, "R10 unmapped");
      rd(7, 32'h0, "R10 unmapped low");
      wr(2, 12'hFFF);
      wr(0, 12'hFFF);
      rd(2, 32'h0, "R10 raw write ignored");
      rd(1, 32'h8FF, "R10 mask untouched");

      finish_run();
   end
endmodule